// File: doc/BRIEF.md
# Scale-Space Keypoint Detector

This block scans three neighbouring difference-of-Gaussian layers of one octave and marks pixels of the middle layer that qualify as stable keypoints. The three layers arrive together as one signed sample each per cycle, in raster order. A qualifier marks each sample, and a start-of-frame marker resets the position counters. Each layer feeds its own 3×3 neighbourhood generator, built from two line delays and a shift window. A pipeline then tests the centre sample of the middle layer in three ways at once: it must be a strict extremum over its 26 neighbours, it must have enough contrast, and its curvature must not be edge-like.

The block reports one result for every interior centre pixel. The result carries the centre coordinates and a keypoint flag. Pixels on the one-pixel frame border never produce a result. The contrast floor is an input, so the surrounding system can move it per octave. The edge-ratio limit is a parameter, 10 by default.

Top module: `sk_keypoint_det`

## Requirements
- R1: Synchronous active-low reset clears `out_valid` and `out_key`. A result still in flight when reset is asserted never appears.
- R2: Position counters advance only on accepted samples and wrap at `IMG_W` columns and `IMG_H` rows. A sample with `in_sof` high is taken as column 0, row 0, whatever the counters held.
- R3: The result for centre (cx, cy) is registered on the second rising edge after the edge that accepts sample (cx+1, cy+1). At that point `out_x`/`out_y` equal cx/cy.
- R4: Results appear only for centres with 1 ≤ cx ≤ `IMG_W`-2 and 1 ≤ cy ≤ `IMG_H`-2. There is exactly one result per such centre per frame, in raster order.
- R5: A centre is an extremum when it is strictly greater than all 26 neighbours, or strictly less than all of them. The neighbours are 9 in the lower layer, 8 in the middle layer and 9 in the upper layer. A tie disqualifies the centre.
- R6: The contrast test passes when |centre| ≥ `contrast_min`, with `contrast_min` read as unsigned.
- R7: The edge test uses the middle layer: dxx = left + right − 2·centre, dyy = up + down − 2·centre, and q = (down-right − down-left − up-right + up-left). With T = dxx + dyy and P = 16·dxx·dyy − q², it passes when P > 0 and 16·r·T² < (r+1)²·P. Here r = `EDGE_R`, which is 10 by default. Equality fails.
- R8: `out_key` is high only together with `out_valid`, and equals the AND of R5, R6 and R7 for that centre.
- R9: Cycles with `in_valid` low move no window and no counter. Samples presented on those cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | The three samples on this cycle are accepted |
| in_sof | input | 1 | This accepted sample is column 0, row 0 |
| in_dog_lo | input | DW | Lower-scale layer sample, signed |
| in_dog_mid | input | DW | Middle layer sample, signed |
| in_dog_hi | input | DW | Upper-scale layer sample, signed |
| contrast_min | input | DW | Unsigned contrast floor |
| out_valid | output | 1 | A result for an interior centre is present |
| out_key | output | 1 | The centre is a stable keypoint |
| out_x | output | $clog2(IMG_W) | Centre column |
| out_y | output | $clog2(IMG_H) | Centre row |

## Verification
The hardest cases to reach from the ports are centres that already pass the strict 26-neighbour test and the contrast floor, yet sit exactly on the curvature-ratio boundary or have a non-positive determinant caused only by the cross term. The stimulus reaches them by placing one hand-built 3×3×3 neighbourhood in an otherwise zero frame. Its neighbour values are chosen so that dxx, dyy and q come out at the wanted numbers: equality at r = 10, one step inside it, and a saddle made by the diagonals alone. Every other centre of each frame is compared against a model built from the requirements. Further frames cover stalls with junk data on idle cycles, a re-sync through the start-of-frame marker, and a reset that cancels a pending result.

// File: rtl/sk_pkg.sv
// Shared constants for the keypoint detector: layer numbering and window
// geometry. The 3x3 window is stored row-major, row 0 = oldest line (top),
// column 0 = oldest sample (left), so index 4 is the centre.
package sk_pkg;
    localparam int WIN_N  = 9;
    localparam int CTR    = 4;
    localparam int LAY_LO  = 0;
    localparam int LAY_MID = 1;
    localparam int LAY_HI  = 2;
    localparam int N_LAY   = 3;
endpackage

// File: rtl/sk_rastpos.sv
// Raster position tracker. Counts accepted samples into column/row,
// re-anchors on the start-of-frame marker and produces the stage-A
// qualifier and centre coordinates for the window that the current sample
// completes. Assumes exactly IMG_W samples per line.
module sk_rastpos #(
    parameter int IMG_W = 32,
    parameter int IMG_H = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    output logic [$clog2(IMG_W)-1:0]   pix_x,
    output logic                       a_valid,
    output logic [$clog2(IMG_W)-1:0]   a_x,
    output logic [$clog2(IMG_H)-1:0]   a_y
);
    localparam int XW = $clog2(IMG_W);
    localparam int YW = $clog2(IMG_H);

    logic [XW-1:0] x_cnt, cur_x;
    logic [YW-1:0] y_cnt, cur_y;

    // Position of the sample on the inputs now (start-of-frame overrides).
    always_comb begin
        cur_x = in_sof ? '0 : x_cnt;
        cur_y = in_sof ? '0 : y_cnt;
    end

    assign pix_x = cur_x;

    // Advance the raster counters on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_cnt <= '0;
            y_cnt <= '0;
        end else if (in_valid) begin
            if (cur_x == XW'(IMG_W - 1)) begin
                x_cnt <= '0;
                y_cnt <= (cur_y == YW'(IMG_H - 1)) ? '0 : cur_y + YW'(1);
            end else begin
                x_cnt <= cur_x + XW'(1);
                y_cnt <= cur_y;
            end
        end
    end

    // Stage A: qualify windows whose centre lies off the frame border.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_x     <= '0;
            a_y     <= '0;
        end else begin
            a_valid <= in_valid && (cur_x >= XW'(2)) && (cur_y >= YW'(2));
            if (in_valid) begin
                a_x <= cur_x - XW'(1);
                a_y <= cur_y - YW'(1);
            end
        end
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(x_cnt) < IMG_W); // R2
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n) a_valid |-> $past(in_valid)); // R9
endmodule

// File: rtl/sk_win3.sv
// 3x3 neighbourhood generator for one layer. Two line delays hold the two
// previous rows; a shift window takes one new column per accepted sample.
// Assumes the caller supplies the column index of the incoming sample.
// Line memories carry no reset: every location is written before use.
module sk_win3
    import sk_pkg::*;
#(
    parameter int DW    = 10,
    parameter int IMG_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            adv,
    input  logic [$clog2(IMG_W)-1:0]        col,
    input  logic [DW-1:0]                   din,
    output logic [WIN_N-1:0][DW-1:0]        win
);
    logic [DW-1:0] line1 [IMG_W];
    logic [DW-1:0] line2 [IMG_W];
    logic [2:0][DW-1:0] tap;

    // Vertical taps for the current column: two rows back, one back, now.
    always_comb begin
        tap[0] = line2[col];
        tap[1] = line1[col];
        tap[2] = din;
    end

    // Line delays: push the column down one row on each accepted sample.
    always_ff @(posedge clk) begin
        if (adv) begin
            line2[col] <= line1[col];
            line1[col] <= din;
        end
    end

    // Shift window: newest column enters on the right.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (adv) begin
            for (int r = 0; r < 3; r++) begin
                win[r*3+2] <= tap[r];
                win[r*3+1] <= win[r*3+2];
                win[r*3+0] <= win[r*3+1];
            end
        end
    end
endmodule

// File: rtl/sk_extremum.sv
// Strict 26-neighbour extremum test on the middle-layer centre against the
// full lower and upper windows and the 8 middle-layer neighbours.
// Purely combinational; assumes all windows describe the same position.
module sk_extremum
    import sk_pkg::*;
#(
    parameter int DW = 10
) (
    input  logic [WIN_N-1:0][DW-1:0] lo,
    input  logic [WIN_N-1:0][DW-1:0] mid,
    input  logic [WIN_N-1:0][DW-1:0] hi,
    output logic                     is_ext
);
    logic signed [DW-1:0] c;
    logic gt, lt;

    // Clear the max/min candidates on any neighbour that is not strictly beaten.
    always_comb begin
        c  = $signed(mid[CTR]);
        gt = 1'b1;
        lt = 1'b1;
        for (int k = 0; k < WIN_N; k++) begin
            if (c <= $signed(lo[k])) gt = 1'b0;
            if (c >= $signed(lo[k])) lt = 1'b0;
            if (c <= $signed(hi[k])) gt = 1'b0;
            if (c >= $signed(hi[k])) lt = 1'b0;
            if (k != CTR) begin
                if (c <= $signed(mid[k])) gt = 1'b0;
                if (c >= $signed(mid[k])) lt = 1'b0;
            end
        end
        is_ext = gt | lt;
    end
endmodule

// File: rtl/sk_edge_test.sv
// Integer curvature-ratio test. Takes the second differences dxx, dyy and
// the four-times-scaled cross difference q; with P = 16*dxx*dyy - q*q and
// T = dxx + dyy it passes when P > 0 and 16*R*T^2 < (R+1)^2*P. Exact, no
// division. Combinational; the internal width covers the worst case.
module sk_edge_test #(
    parameter int DW     = 10,
    parameter int EDGE_R = 10
) (
    input  logic signed [DW+1:0] dxx,
    input  logic signed [DW+1:0] dyy,
    input  logic signed [DW+1:0] q,
    output logic                 pass
);
    localparam int PW = 2*DW + 16;
    localparam logic signed [PW-1:0] K_TR  = PW'(16 * EDGE_R);
    localparam logic signed [PW-1:0] K_DET = PW'((EDGE_R + 1) * (EDGE_R + 1));

    logic signed [PW-1:0] tr, det16, lhs, rhs;

    // Trace, scaled determinant and both sides of the ratio inequality.
    always_comb begin
        tr    = PW'(dxx) + PW'(dyy);
        det16 = ((PW'(dxx) * PW'(dyy)) <<< 4) - (PW'(q) * PW'(q));
        lhs   = tr * tr * K_TR;
        rhs   = det16 * K_DET;
        pass  = !det16[PW-1] && (det16 != '0) && (lhs < rhs);
    end
endmodule

// File: rtl/sk_keypoint_det.sv
// Scale-space keypoint detector. Three signed layer samples per accepted
// cycle, raster order. Per-layer 3x3 windows feed a two-stage pipeline:
// stage B registers extremum, contrast and the finite differences; stage C
// applies the curvature test and registers the result with its centre
// position. Assumes frames of exactly IMG_W x IMG_H samples.
module sk_keypoint_det
    import sk_pkg::*;
#(
    parameter int IMG_W  = 32,
    parameter int IMG_H  = 24,
    parameter int DW     = 10,
    parameter int EDGE_R = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic signed [DW-1:0]       in_dog_lo,
    input  logic signed [DW-1:0]       in_dog_mid,
    input  logic signed [DW-1:0]       in_dog_hi,
    input  logic [DW-1:0]              contrast_min,
    output logic                       out_valid,
    output logic                       out_key,
    output logic [$clog2(IMG_W)-1:0]   out_x,
    output logic [$clog2(IMG_H)-1:0]   out_y
);
    localparam int XW = $clog2(IMG_W);
    localparam int YW = $clog2(IMG_H);
    localparam int EW = DW + 2;

    logic [XW-1:0] pix_x, a_x, b_x;
    logic [YW-1:0] a_y, b_y;
    logic          a_valid, b_valid;
    logic [N_LAY-1:0][DW-1:0]            din_l;
    logic [N_LAY-1:0][WIN_N-1:0][DW-1:0] wins;

    logic                 ext_c, con_c, edge_ok;
    logic signed [EW-1:0] dxx_c, dyy_c, q_c, ctr_e;
    logic [EW-1:0]        ctr_abs;
    logic                 b_ext, b_con;
    logic signed [EW-1:0] b_dxx, b_dyy, b_q;

    assign din_l = {in_dog_hi, in_dog_mid, in_dog_lo};

    sk_rastpos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .pix_x(pix_x), .a_valid(a_valid), .a_x(a_x), .a_y(a_y)
    );

    for (genvar g = 0; g < N_LAY; g++) begin : g_layer
        sk_win3 #(.DW(DW), .IMG_W(IMG_W)) u_win (
            .clk(clk), .rst_n(rst_n), .adv(in_valid), .col(pix_x),
            .din(din_l[g]), .win(wins[g])
        );
    end

    sk_extremum #(.DW(DW)) u_ext (
        .lo(wins[LAY_LO]), .mid(wins[LAY_MID]), .hi(wins[LAY_HI]), .is_ext(ext_c)
    );

    // Finite differences and contrast magnitude on the middle window.
    always_comb begin
        ctr_e   = EW'($signed(wins[LAY_MID][CTR]));
        dxx_c   = EW'($signed(wins[LAY_MID][3])) + EW'($signed(wins[LAY_MID][5])) - (ctr_e <<< 1);
        dyy_c   = EW'($signed(wins[LAY_MID][1])) + EW'($signed(wins[LAY_MID][7])) - (ctr_e <<< 1);
        q_c     = EW'($signed(wins[LAY_MID][8])) - EW'($signed(wins[LAY_MID][6]))
                - EW'($signed(wins[LAY_MID][2])) + EW'($signed(wins[LAY_MID][0]));
        ctr_abs = ctr_e[EW-1] ? EW'(-ctr_e) : EW'(ctr_e);
        con_c   = ctr_abs >= EW'(contrast_min);
    end

    // Stage B: register the parallel tests and the curvature terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_x     <= '0;
            b_y     <= '0;
            b_ext   <= 1'b0;
            b_con   <= 1'b0;
            b_dxx   <= '0;
            b_dyy   <= '0;
            b_q     <= '0;
        end else begin
            b_valid <= a_valid;
            b_x     <= a_x;
            b_y     <= a_y;
            b_ext   <= ext_c;
            b_con   <= con_c;
            b_dxx   <= dxx_c;
            b_dyy   <= dyy_c;
            b_q     <= q_c;
        end
    end

    sk_edge_test #(.DW(DW), .EDGE_R(EDGE_R)) u_edge (
        .dxx(b_dxx), .dyy(b_dyy), .q(b_q), .pass(edge_ok)
    );

    // Stage C: combine the three verdicts and present the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_key   <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= b_valid;
            out_key   <= b_valid && b_ext && b_con && edge_ok;
            out_x     <= b_x;
            out_y     <= b_y;
        end
    end

    AST_KEY_QUAL: assert property (@(posedge clk) disable iff (!rst_n) out_key |-> out_valid); // R8
    AST_BORDER: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (int'(out_x) >= 1 && int'(out_x) <= IMG_W-2 && int'(out_y) >= 1 && int'(out_y) <= IMG_H-2)); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 3)); // R3
    AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n) out_key |-> $past(b_ext)); // R5
    AST_CON_GATE: assert property (@(posedge clk) disable iff (!rst_n) out_key |-> $past(b_con)); // R6
endmodule

// File: tb/sk_keypoint_det_tb.sv
module sk_keypoint_det_tb;
    localparam int W  = 5;
    localparam int H  = 5;
    localparam int DW = 10;
    localparam int NV = 12;
    localparam int NC = (W-2)*(H-2);

    typedef struct packed {
        int c; int nx; int ny; int nd; int dg; int na; int nb; int thr; int req; bit ex;
    } vec_t;

    // c, left/right, up/down, diag base, diag skew, upper layer, lower layer, floor, req, expected
    localparam vec_t VEC [NV] = '{
        '{ 40,  10,  10,  10,  0,  5,  5, 3, 5, 1'b1},   // R5 maximum
        '{-40, -10, -10, -10,  0, -5, -5, 3, 5, 1'b1},   // R5 minimum
        '{  2,   0,   0,   0,  0,  0,  0, 3, 6, 1'b0},   // R6 below floor
        '{  2,   0,   0,   0,  0,  0,  0, 2, 6, 1'b1},   // R6 equal to floor
        '{ 40,  39,   0,   0,  0,  0,  0, 3, 7, 1'b0},   // R7 strong edge
        '{ 40,  30,  39,   0,  0,  0,  0, 3, 7, 1'b0},   // R7 ratio exactly 10
        '{ 40,  30,  38,   0,  0,  0,  0, 3, 7, 1'b1},   // R7 ratio just inside
        '{ 40,  39,  39,  20, 19,  0,  0, 3, 7, 1'b0},   // R7 saddle from cross term
        '{ 40,  30,  30,  30,  9,  0,  0, 3, 7, 1'b1},   // R7 cross term tolerated
        '{ 40,  10,  10,  10,  0, 40,  5, 3, 5, 1'b0},   // R5 tie in upper layer
        '{ 40,  10,  10,  10,  0, 41,  5, 3, 5, 1'b0},   // R5 upper layer larger
        '{ 40,  10,  10,  10,  0,  5, 39, 3, 5, 1'b1}    // R5 lower layer just below
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0;
    logic signed [DW-1:0] in_dog_lo = '0, in_dog_mid = '0, in_dog_hi = '0;
    logic [DW-1:0] contrast_min = 10'd3;
    logic out_valid, out_key;
    logic [$clog2(W)-1:0] out_x;
    logic [$clog2(H)-1:0] out_y;

    sk_keypoint_det #(.IMG_W(W), .IMG_H(H), .DW(DW), .EDGE_R(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_dog_lo(in_dog_lo), .in_dog_mid(in_dog_mid), .in_dog_hi(in_dog_hi),
        .contrast_min(contrast_min), .out_valid(out_valid), .out_key(out_key),
        .out_x(out_x), .out_y(out_y)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, ec = 0;
    int fl [H][W], fm [H][W], fh [H][W];
    bit ek [H][W];
    int acc [H][W];
    int idx = 0, vi = -1;
    bit stray_key = 1'b0;

    always @(posedge clk) ec <= ec + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_key(int cx, int cy, int thr);
        int c;
        bit gt, lt, edge_ok, con;
        longint dxx, dyy, q, tr, det;
        c = fm[cy][cx]; gt = 1; lt = 1;
        for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++) begin
                if (!(c > fl[cy+dy][cx+dx])) gt = 0;
                if (!(c < fl[cy+dy][cx+dx])) lt = 0;
                if (!(c > fh[cy+dy][cx+dx])) gt = 0;
                if (!(c < fh[cy+dy][cx+dx])) lt = 0;
                if (dx != 0 || dy != 0) begin
                    if (!(c > fm[cy+dy][cx+dx])) gt = 0;
                    if (!(c < fm[cy+dy][cx+dx])) lt = 0;
                end
            end
        dxx = fm[cy][cx-1] + fm[cy][cx+1] - 2*c;
        dyy = fm[cy-1][cx] + fm[cy+1][cx] - 2*c;
        q   = fm[cy+1][cx+1] - fm[cy+1][cx-1] - fm[cy-1][cx+1] + fm[cy-1][cx-1];
        tr  = dxx + dyy;
        det = 16*dxx*dyy - q*q;
        edge_ok = (det > 0) && (160*tr*tr < 121*det);
        con = ((c < 0) ? -c : c) >= thr;
        return (gt || lt) && edge_ok && con;
    endfunction

    task automatic load_vec(int v);
        vec_t p;
        p = VEC[v];
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                fl[y][x] = 0; fm[y][x] = 0; fh[y][x] = 0;
            end
        for (int y = 1; y <= 3; y++)
            for (int x = 1; x <= 3; x++) begin
                fl[y][x] = p.nb; fh[y][x] = p.na;
            end
        fm[2][2] = p.c;
        fm[2][1] = p.nx; fm[2][3] = p.nx;
        fm[1][2] = p.ny; fm[3][2] = p.ny;
        fm[1][1] = p.nd + p.dg; fm[3][3] = p.nd + p.dg;
        fm[1][3] = p.nd - p.dg; fm[3][1] = p.nd - p.dg;
        contrast_min = DW'(p.thr);
        for (int y = 1; y < H-1; y++)
            for (int x = 1; x < W-1; x++) ek[y][x] = model_key(x, y, p.thr);
        idx = 0; stray_key = 0; vi = v;
    endtask

    task automatic send_frame(int gap);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_sof = (x == 0 && y == 0);
                in_dog_lo = fl[y][x][DW-1:0];
                in_dog_mid = fm[y][x][DW-1:0];
                in_dog_hi = fh[y][x][DW-1:0];
                acc[y][x] = ec + 1;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_sof = 1'b1;
                    in_dog_lo = 10'sh155; in_dog_mid = 10'sh1FF; in_dog_hi = -10'sd300;
                end
            end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic end_frame(string req);
        chk(idx == NC, req, "results per frame", idx, NC);
        chk(!stray_key, "R8", "key without valid", int'(stray_key), 0);
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        int ecx, ecy;
        if (rst_n && out_key && !out_valid) stray_key = 1'b1;
        if (rst_n && out_valid) begin
            if (idx >= NC) begin
                chk(0, "R4", "extra result", idx + 1, NC);
            end else begin
                ecx = 1 + idx % (W-2);
                ecy = 1 + idx / (W-2);
                chk(int'(out_x) == ecx && int'(out_y) == ecy, "R2", "centre position y*W+x",
                    int'(out_y)*W + int'(out_x), ecy*W + ecx);
                chk(ec == acc[ecy+1][ecx+1] + 2, "R3", "latency in edges",
                    ec - acc[ecy+1][ecx+1], 2);
                chk(out_key == ek[ecy][ecx], "R8", "key against model", int'(out_key), int'(ek[ecy][ecx]));
                if (vi >= 0 && ecx == 2 && ecy == 2)
                    chk(out_key == VEC[vi].ex, $sformatf("R%0d", VEC[vi].req),
                        $sformatf("vector %0d key", vi), int'(out_key), int'(VEC[vi].ex));
            end
            idx++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", "run did not finish", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_key == 0, "R1", "outputs in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_key == 0, "R1", "outputs idle after reset", int'(out_valid), 0);

        // Table walk: each vector is a full frame, checked by the monitor.
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            send_frame(0);
            end_frame("R4");
        end

        // R9: stalls with junk on idle cycles give identical results.
        load_vec(0);
        send_frame(2);
        end_frame("R9");

        // R2: start-of-frame marker re-anchors a misaligned raster.
        load_vec(8);
        for (int j = 0; j < 7; j++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0;
            in_dog_lo = 10'sd7; in_dog_mid = -10'sd90; in_dog_hi = 10'sd60;
        end
        send_frame(0);
        end_frame("R2");

        // R1: reset mid-frame cancels the pending result of centre (1,1).
        load_vec(0);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (k == 0);
            in_dog_lo = fl[k/W][k%W][DW-1:0];
            in_dog_mid = fm[k/W][k%W][DW-1:0];
            in_dog_hi = fh[k/W][k%W][DW-1:0];
        end
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
        chk(out_valid == 0 && out_key == 0, "R1", "pending result cancelled", int'(out_valid), 0);
        chk(idx == 0, "R1", "no result escaped before reset", idx, 0);
        rst_n = 1'b1;
        load_vec(0);
        send_frame(0);
        end_frame("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule